// File: doc/BRIEF.md
# SPI Controller Host Register File with Transmit and Receive FIFOs

This block is the software-visible face of an SPI controller. A simple 32-bit register bus reaches ten word registers: enable, serial clock setup, transmit and receive word format, frame-select setup, status, interrupt enable, interrupt clear, FIFO control and a shared data port. Each of the two FIFOs holds eight words. A write to the data port queues a word for the serial engine. A read of the same port takes the oldest received word.

The serial engine sits on the other side. It takes words with a pop strobe and delivers them with a push strobe. It reports activity with a busy level and the end of a transfer with a done pulse. It reads its setup from the configuration outputs. Three sticky event flags drive one interrupt line through an enable mask. Software clears a flag by writing a one to it.

Top module: `spi_regif`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, except status, which reads 0x20 (transmit not full). The irq output and eng_tx_valid are 0.
- R2: Each configuration register reads back the last value written, masked to its writable bits. Enable (0x00) keeps bit 0. Clock (0x04) keeps bits 14:12 and 7:0. Transmit format (0x08) keeps bits 13:0. Receive format (0x0C) keeps bits 7:0. Frame (0x10) keeps bits 15:14. Interrupt enable (0x18) keeps bits 4, 3 and 0. Unmapped word addresses read 0. Each value also appears on its cfg output the cycle after the write.
- R3: A write to the data address 0x24 queues the word in the transmit FIFO, unless that FIFO already holds 8 words. eng_tx_valid is high whenever the FIFO is non-empty. eng_tx_data shows the oldest word, and an eng_tx_pop removes that word. Words leave in the order they were written.
- R4: A data write while the transmit FIFO holds 8 words is dropped, even if the engine pops in the same cycle. The contents and order of the stored words are unchanged.
- R5: A word pushed by the engine is appended to the receive FIFO. A bus read of 0x24 returns the oldest received word and removes it. When that FIFO is empty, the read returns 0 and removes nothing.
- R6: Status (0x14) shows three bits. Bit 7 is eng_busy OR'd with "transmit FIFO non-empty". Bit 5 is "transmit FIFO holds fewer than 8". Bit 0 is "receive FIFO non-empty". All other bits read 0.
- R7: In FIFO control (0x20), writing bit 12 empties the transmit FIFO and writing bit 4 empties the receive FIFO, both at that clock edge. Any engine or bus transfer on a FIFO in its flush cycle is dropped. The flush bits read back 0. Bits 11:8 (transmit threshold) and 3:0 (receive threshold) are stored, read back and driven on cfg_tx_thr and cfg_rx_thr.
- R8: An engine push while the receive FIFO holds 8 words is dropped, even if the bus reads in the same cycle. The push sets the overrun flag (bit 0).
- R9: Reading interrupt clear (0x1C) returns the sticky flags. Bit 4 is set by eng_done. Bit 3 is set by each word accepted into the receive FIFO. Bit 0 is overrun. Writing 1 to a bit clears it. If a flag is set and cleared in the same cycle, the set wins.
- R10: irq is high exactly when some flag bit is high and the same bit is set in interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address; bits 5:2 select the word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops on the data address) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| eng_tx_valid | output | 1 | Transmit FIFO non-empty |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_busy | input | 1 | Engine is shifting |
| eng_done | input | 1 | Transfer-complete pulse |
| cfg_enable | output | 1 | Controller enable |
| cfg_clock | output | 32 | Clock setup register |
| cfg_tx_fmt | output | 32 | Transmit word format |
| cfg_rx_fmt | output | 32 | Receive word format |
| cfg_frame | output | 32 | Frame-select setup |
| cfg_tx_thr | output | 4 | Transmit threshold |
| cfg_rx_thr | output | 4 | Receive threshold |
| irq | output | 1 | Interrupt request |

## Verification
Several traffic patterns are run, and each separates a different class of fault.

- **Short bursts** of transmit and receive words separate ordering faults from level faults.
- **Filling either FIFO to eight and one beyond** tells an off-by-one full test from a correct one. It also shows whether the extra word was really dropped.
- **Pushing and popping a full FIFO in the same cycle** separates a full test on the state before the edge from one on the state after it.
- **Flush writes combined with threshold values** show whether the flush bits leak into the readback.
- **Setting and clearing a flag in the same cycle**, under varied enable masks, pins down the priority of the sticky flags and the interrupt masking.

// File: rtl/spi_regif_pkg.sv
// Package: register indices, writable masks and bit positions shared by the
// register file and its submodules. Assumes 32-bit registers on a byte bus.
package spi_regif_pkg;

    localparam int REG_W = 32;

    typedef enum logic [3:0] {
        IDX_CTL   = 4'd0,
        IDX_CLK   = 4'd1,
        IDX_TXFMT = 4'd2,
        IDX_RXFMT = 4'd3,
        IDX_FRAME = 4'd4,
        IDX_STAT  = 4'd5,
        IDX_IEN   = 4'd6,
        IDX_ICLR  = 4'd7,
        IDX_FCTL  = 4'd8,
        IDX_DATA  = 4'd9
    } reg_idx_e;

    localparam logic [REG_W-1:0] MASK_CLK   = 32'h0000_70FF;
    localparam logic [REG_W-1:0] MASK_TXFMT = 32'h0000_3FFF;
    localparam logic [REG_W-1:0] MASK_RXFMT = 32'h0000_00FF;
    localparam logic [REG_W-1:0] MASK_FRAME = 32'h0000_C000;
    localparam logic [REG_W-1:0] MASK_IRQ   = 32'h0000_0019;

    localparam int ST_BUSY = 7;
    localparam int ST_TNF  = 5;
    localparam int ST_RNE  = 0;

    localparam int FC_TXFL  = 12;
    localparam int FC_RXFL  = 4;
    localparam int TH_W     = 4;
    localparam int FC_TXTH  = 8;
    localparam int FC_RXTH  = 0;

    // internal flag vector order and register bit positions
    localparam int FLAG_N   = 3;
    localparam int FL_OVR   = 0;
    localparam int FL_RC    = 1;
    localparam int FL_TC    = 2;
    localparam int BIT_OVR  = 0;
    localparam int BIT_RC   = 3;
    localparam int BIT_TC   = 4;

    function automatic logic [REG_W-1:0] flags_to_reg(input logic [FLAG_N-1:0] f);
        logic [REG_W-1:0] r;
        r          = '0;
        r[BIT_OVR] = f[FL_OVR];
        r[BIT_RC]  = f[FL_RC];
        r[BIT_TC]  = f[FL_TC];
        return r;
    endfunction

    function automatic logic [FLAG_N-1:0] reg_to_flags(input logic [REG_W-1:0] r);
        logic [FLAG_N-1:0] f;
        f[FL_OVR] = r[BIT_OVR];
        f[FL_RC]  = r[BIT_RC];
        f[FL_TC]  = r[BIT_TC];
        return f;
    endfunction

endpackage

// File: rtl/spi_regif_fifo.sv
// Module: synchronous FIFO with a flush strobe.
// Flush has priority and drops any push or pop in its cycle. A push is taken
// only when the FIFO was not full before the edge, a pop only when it was not
// empty. The head word is visible combinationally.
module spi_regif_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] level;
    logic             do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write: no reset needed, contents are qualified by level.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and level update, flush returns both pointers to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    p_full_push_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);

    p_empty_pop_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> empty);

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/spi_regif_flags.sv
// Module: sticky event flags with write-one-to-clear.
// A set and a clear on the same bit in one cycle leave the bit set.
module spi_regif_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    // Flag update: clear first, then set, so set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end

    p_set_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((flags & $past(set)) == $past(set)));

    p_clear_works_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~set) != '0) |=> ((flags & $past(clr & ~set)) == '0));

endmodule

// File: rtl/spi_regif.sv
// Module: host register file and FIFO pair of an SPI controller.
// Assumes a single-cycle register bus: writes land at the clock edge, read
// data is combinational for bus_addr, and a read strobe on the data address
// pops the receive FIFO at the edge. Requires ADDR_W >= 6 and WORD_W <= 32.
module spi_regif
    import spi_regif_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int WORD_W     = 32,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              eng_tx_valid,
    output logic [WORD_W-1:0] eng_tx_data,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [WORD_W-1:0] eng_rx_data,
    input  logic              eng_busy,
    input  logic              eng_done,
    output logic              cfg_enable,
    output logic [REG_W-1:0]  cfg_clock,
    output logic [REG_W-1:0]  cfg_tx_fmt,
    output logic [REG_W-1:0]  cfg_rx_fmt,
    output logic [REG_W-1:0]  cfg_frame,
    output logic [TH_W-1:0]   cfg_tx_thr,
    output logic [TH_W-1:0]   cfg_rx_thr,
    output logic              irq
);
    localparam int WI_W = ADDR_W - 2;

    logic [WI_W-1:0]   wi;
    logic              unused_addr_lsbs;
    logic              en_q;
    logic [REG_W-1:0]  clk_q, txf_q, rxf_q, frm_q, ien_q;
    logic [TH_W-1:0]   txth_q, rxth_q;
    logic              wr_ctl, wr_clk, wr_txf, wr_rxf, wr_frm, wr_ien, wr_iclr, wr_fctl, wr_data;
    logic              rd_data;
    logic              tx_flush, rx_flush;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [WORD_W-1:0] rx_head;
    logic [FLAG_N-1:0] fl_set, fl_clr, flags;
    logic [REG_W-1:0]  flag_reg, status;

    assign wi               = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsbs = ^bus_addr[1:0];

    // Address decode into per-register strobes.
    always_comb begin
        wr_ctl  = bus_wr && (wi == WI_W'(IDX_CTL));
        wr_clk  = bus_wr && (wi == WI_W'(IDX_CLK));
        wr_txf  = bus_wr && (wi == WI_W'(IDX_TXFMT));
        wr_rxf  = bus_wr && (wi == WI_W'(IDX_RXFMT));
        wr_frm  = bus_wr && (wi == WI_W'(IDX_FRAME));
        wr_ien  = bus_wr && (wi == WI_W'(IDX_IEN));
        wr_iclr = bus_wr && (wi == WI_W'(IDX_ICLR));
        wr_fctl = bus_wr && (wi == WI_W'(IDX_FCTL));
        wr_data = bus_wr && (wi == WI_W'(IDX_DATA));
        rd_data = bus_rd && (wi == WI_W'(IDX_DATA));
    end

    assign tx_flush = wr_fctl && bus_wdata[FC_TXFL];
    assign rx_flush = wr_fctl && bus_wdata[FC_RXFL];

    // Configuration registers, each masked to its writable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            clk_q  <= '0;
            txf_q  <= '0;
            rxf_q  <= '0;
            frm_q  <= '0;
            ien_q  <= '0;
            txth_q <= '0;
            rxth_q <= '0;
        end else begin
            if (wr_ctl) en_q  <= bus_wdata[0];
            if (wr_clk) clk_q <= bus_wdata & MASK_CLK;
            if (wr_txf) txf_q <= bus_wdata & MASK_TXFMT;
            if (wr_rxf) rxf_q <= bus_wdata & MASK_RXFMT;
            if (wr_frm) frm_q <= bus_wdata & MASK_FRAME;
            if (wr_ien) ien_q <= bus_wdata & MASK_IRQ;
            if (wr_fctl) begin
                txth_q <= bus_wdata[FC_TXTH +: TH_W];
                rxth_q <= bus_wdata[FC_RXTH +: TH_W];
            end
        end
    end

    spi_regif_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (wr_data),
        .push_data (WORD_W'(bus_wdata)),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    spi_regif_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rd_data),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    // Flag events: accepted receive word, dropped receive word, transfer done.
    always_comb begin
        fl_set         = '0;
        fl_set[FL_TC]  = eng_done;
        fl_set[FL_RC]  = eng_rx_push && !rx_full && !rx_flush;
        fl_set[FL_OVR] = eng_rx_push && rx_full && !rx_flush;
        fl_clr         = wr_iclr ? reg_to_flags(bus_wdata) : '0;
    end

    spi_regif_flags #(.N(FLAG_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fl_set),
        .clr   (fl_clr),
        .flags (flags)
    );

    assign flag_reg     = flags_to_reg(flags);
    assign irq          = |(flag_reg & ien_q);
    assign eng_tx_valid = !tx_empty;

    // Status word assembly.
    always_comb begin
        status          = '0;
        status[ST_BUSY] = eng_busy || !tx_empty;
        status[ST_TNF]  = !tx_full;
        status[ST_RNE]  = !rx_empty;
    end

    // Read data multiplexer; the data port reads 0 when nothing is queued.
    always_comb begin
        bus_rdata = '0;
        case (wi)
            WI_W'(IDX_CTL):   bus_rdata = {{(REG_W-1){1'b0}}, en_q};
            WI_W'(IDX_CLK):   bus_rdata = clk_q;
            WI_W'(IDX_TXFMT): bus_rdata = txf_q;
            WI_W'(IDX_RXFMT): bus_rdata = rxf_q;
            WI_W'(IDX_FRAME): bus_rdata = frm_q;
            WI_W'(IDX_STAT):  bus_rdata = status;
            WI_W'(IDX_IEN):   bus_rdata = ien_q;
            WI_W'(IDX_ICLR):  bus_rdata = flag_reg;
            WI_W'(IDX_FCTL): begin
                bus_rdata[FC_TXTH +: TH_W] = txth_q;
                bus_rdata[FC_RXTH +: TH_W] = rxth_q;
            end
            WI_W'(IDX_DATA):  bus_rdata = rx_empty ? '0 : REG_W'(rx_head);
            default:          bus_rdata = '0;
        endcase
    end

    assign cfg_enable = en_q;
    assign cfg_clock  = clk_q;
    assign cfg_tx_fmt = txf_q;
    assign cfg_rx_fmt = rxf_q;
    assign cfg_frame  = frm_q;
    assign cfg_tx_thr = txth_q;
    assign cfg_rx_thr = rxth_q;

    p_overrun_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !rx_flush) |=> flags[FL_OVR]);

    p_done_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> flags[FL_TC]);

    p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

    p_busy_when_queued_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_valid |-> status[ST_BUSY]);

endmodule

// File: tb/spi_regif_tb_top.sv
// Bench: behavioural model with queues, compared with the DUT on every clock.
module spi_regif_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = 6'h14;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_tx_valid;
    logic [31:0] eng_tx_data;
    logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic        eng_busy = 1'b0, eng_done = 1'b0;
    logic        cfg_enable;
    logic [31:0] cfg_clock, cfg_tx_fmt, cfg_rx_fmt, cfg_frame;
    logic [3:0]  cfg_tx_thr, cfg_rx_thr;
    logic        irq;

    always #4 clk = ~clk;

    spi_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_busy(eng_busy), .eng_done(eng_done),
        .cfg_enable(cfg_enable), .cfg_clock(cfg_clock), .cfg_tx_fmt(cfg_tx_fmt),
        .cfg_rx_fmt(cfg_rx_fmt), .cfg_frame(cfg_frame), .cfg_tx_thr(cfg_tx_thr),
        .cfg_rx_thr(cfg_rx_thr), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    logic [31:0] m_ctl, m_clk, m_txf, m_rxf, m_frm, m_ien, m_flags;
    logic [3:0]  m_txth, m_rxth;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rdata(input logic [3:0] w);
        logic [31:0] r;
        r = '0;
        case (w)
            4'd0: r = m_ctl;
            4'd1: r = m_clk;
            4'd2: r = m_txf;
            4'd3: r = m_rxf;
            4'd4: r = m_frm;
            4'd5: begin
                r[7] = eng_busy || (txq.size() > 0);
                r[5] = txq.size() < 8;
                r[0] = rxq.size() > 0;
            end
            4'd6: r = m_ien;
            4'd7: r = m_flags;
            4'd8: r = {20'd0, m_txth, 4'd0, m_rxth};
            4'd9: r = (rxq.size() > 0) ? rxq[0] : 32'd0;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] w);
        case (w)
            4'd5: return "R6";
            4'd7: return "R9";
            4'd8: return "R7";
            4'd9: return "R5";
            default: return "R2";
        endcase
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        logic [3:0]  w;
        int          ts, rs;
        logic        txfl, rxfl;
        logic [31:0] setm, clrm;
        w = bus_addr[5:2];
        if (!rst_n) begin
            m_ctl = 0; m_clk = 0; m_txf = 0; m_rxf = 0; m_frm = 0; m_ien = 0;
            m_flags = 0; m_txth = 0; m_rxth = 0;
            txq.delete(); rxq.delete();
        end else begin
            ts = txq.size();
            rs = rxq.size();
            txfl = bus_wr && w == 4'd8 && bus_wdata[12];
            rxfl = bus_wr && w == 4'd8 && bus_wdata[4];
            setm = 0;
            clrm = 0;
            if (eng_done) setm[4] = 1'b1;
            if (eng_rx_push && !rxfl) begin
                if (rs < 8) setm[3] = 1'b1;
                else        setm[0] = 1'b1;
            end
            if (bus_wr && w == 4'd7) clrm = bus_wdata & 32'h19;
            if (txfl) txq.delete();
            else begin
                if (eng_tx_pop && ts > 0) void'(txq.pop_front());
                if (bus_wr && w == 4'd9 && ts < 8) txq.push_back(bus_wdata);
            end
            if (rxfl) rxq.delete();
            else begin
                if (bus_rd && w == 4'd9 && rs > 0) void'(rxq.pop_front());
                if (eng_rx_push && rs < 8) rxq.push_back(eng_rx_data);
            end
            if (bus_wr) begin
                case (w)
                    4'd0: m_ctl = bus_wdata & 32'h1;
                    4'd1: m_clk = bus_wdata & 32'h70FF;
                    4'd2: m_txf = bus_wdata & 32'h3FFF;
                    4'd3: m_rxf = bus_wdata & 32'hFF;
                    4'd4: m_frm = bus_wdata & 32'hC000;
                    4'd6: m_ien = bus_wdata & 32'h19;
                    4'd8: begin m_txth = bus_wdata[11:8]; m_rxth = bus_wdata[3:0]; end
                    default: ;
                endcase
            end
            m_flags = (m_flags & ~clrm) | setm;
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk(tag_of(bus_addr[5:2]), bus_rdata, exp_rdata(bus_addr[5:2]));
            chk("R3", 32'(eng_tx_valid), 32'(txq.size() > 0));
            if (txq.size() > 0) chk("R3", eng_tx_data, txq[0]);
            chk("R10", 32'(irq), 32'(|(m_flags & m_ien)));
            chk("R7", {24'd0, cfg_tx_thr, cfg_rx_thr}, {24'd0, m_txth, m_rxth});
            chk("R2", 32'(cfg_enable), m_ctl);
            chk("R2", cfg_clock, m_clk);
            chk("R2", cfg_tx_fmt, m_txf);
            chk("R2", cfg_rx_fmt, m_rxf);
            chk("R2", cfg_frame, m_frm);
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 6'h14;
    endtask

    task automatic bus_read(input logic [5:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 6'h14;
    endtask

    task automatic eng_push(input logic [31:0] d);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic eng_pop();
        @(negedge clk);
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state seen at the ports
        chk("R1", bus_rdata, 32'h20);
        chk("R1", 32'(irq), 32'd0);
        chk("R1", 32'(eng_tx_valid), 32'd0);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            bus_addr = 6'(a * 4);
            #1;
            if (a != 5) chk("R1", bus_rdata, 32'd0);
        end

        // R2: all-ones and a mixed pattern into every config register
        for (int a = 0; a < 7; a++) if (a != 5) bus_write(6'(a * 4), 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) bus_read(6'(a * 4) & 6'h3C);
        for (int a = 0; a < 7; a++) if (a != 5) bus_write(6'(a * 4), 32'hA5A5_5A5A);
        for (int a = 0; a < 7; a++) bus_read(6'(a * 4));
        bus_write(6'h18, 32'h0);

        // R3: short burst out to the engine
        for (int i = 0; i < 3; i++) bus_write(6'h24, 32'h1000 + i);
        eng_busy = 1'b1;
        repeat (3) eng_pop();
        eng_busy = 1'b0;
        @(negedge clk);
        eng_busy = 1'b1;
        @(negedge clk);
        eng_busy = 1'b0;

        // R4: nine writes, the ninth is dropped
        for (int i = 0; i < 9; i++) bus_write(6'h24, 32'h2000 + i);
        @(negedge clk); #1;
        chk("R4", bus_rdata & 32'h20, 32'h0);
        // full with simultaneous push and pop: push dropped
        @(negedge clk);
        bus_addr = 6'h24; bus_wdata = 32'hDEAD; bus_wr = 1'b1; eng_tx_pop = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; eng_tx_pop = 1'b0; bus_addr = 6'h14;
        repeat (7) eng_pop();
        @(negedge clk); #1;
        chk("R4", 32'(eng_tx_valid), 32'd0);

        // R5: receive burst, then a read of the empty FIFO
        for (int i = 0; i < 3; i++) eng_push(32'h3000 + i);
        repeat (4) bus_read(6'h24);

        // R8: nine pushes, the ninth overruns
        bus_write(6'h18, 32'h19);
        for (int i = 0; i < 9; i++) eng_push(32'h4000 + i);
        @(negedge clk);
        bus_addr = 6'h1C;
        #1;
        chk("R8", bus_rdata & 32'h1, 32'h1);
        // full with simultaneous push and read: push dropped, overrun again
        @(negedge clk);
        bus_addr = 6'h24; bus_rd = 1'b1; eng_rx_push = 1'b1; eng_rx_data = 32'hBEEF;
        @(negedge clk);
        bus_rd = 1'b0; eng_rx_push = 1'b0; bus_addr = 6'h14;
        repeat (9) bus_read(6'h24);

        // R9: clear flags, done pulse, set and clear in one cycle
        bus_write(6'h1C, 32'h19);
        bus_read(6'h1C);
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        bus_read(6'h1C);
        @(negedge clk);
        bus_addr = 6'h1C; bus_wdata = 32'h10; bus_wr = 1'b1; eng_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; eng_done = 1'b0; bus_addr = 6'h1C;
        @(negedge clk);

        // R10: mask variations
        bus_write(6'h18, 32'h08);
        bus_write(6'h18, 32'h10);
        bus_write(6'h1C, 32'h10);
        bus_write(6'h18, 32'h01);
        eng_push(32'h5000);
        bus_write(6'h18, 32'h08);

        // R7: flush each FIFO with thresholds alongside
        for (int i = 0; i < 5; i++) bus_write(6'h24, 32'h6000 + i);
        eng_push(32'h6100);
        bus_write(6'h20, 32'h0000_1A05);
        bus_read(6'h20);
        bus_read(6'h24);
        eng_push(32'h6200);
        bus_write(6'h20, 32'h0000_0F13);
        bus_read(6'h20);
        bus_read(6'h24);
        bus_write(6'h24, 32'h7000);
        eng_pop();

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule